// File: doc/BRIEF.md
# E1 CAS Signaling Receiver

This block takes a 2.048 Mbit/s E1 bit stream whose basic frames are already aligned, so a strobe marks the first bit of every 256-bit frame. It extracts time slot 16 of every frame and locks onto the 16-frame channel associated signaling multiframe. It reports a multiframe AIS condition, the remote multiframe alarm bit and the three spare bits of the alignment word. For each of the 30 voice channels it keeps the 4-bit ABCD signaling code in a small register bank that the host reads one channel at a time.

Stored codes are protected in two ways. A last-look filter accepts a new code only after it has been seen in two multiframes in a row. A freeze state stops all updates while the line reports loss of signal, while a slip is flagged or while multiframe alignment is missing. The freeze state is released one whole multiframe after the last fault clears. Each accepted change marks the channel and raises a sticky interrupt, so the host reads the bank only when something has changed.

Top module: `e1cas_rx`

## Requirements
- R1: `frame_sync` high marks bit 0 of time slot 0. Time slot 16 occupies frame bit positions 128 to 135. Bit 0 of the slot is received first and becomes the most significant bit of the captured byte.
- R2: `mf_lock` rises after slot-16 bits 0-3 read 0000 in two frames that are 16 frames apart. The second of these frames is multiframe frame 0.
- R3: While locked, a single errored alignment word (bits 0-3 not 0000 in frame 0) is tolerated. A second consecutive errored word clears `mf_lock`. A multiframe whose 128 slot-16 bits are all zero also clears `mf_lock`.
- R4: At the end of each 16-frame window, `ais_ts16` is set if the window's slot-16 bits held at most 3 zeros, and cleared otherwise.
- R5: On each good alignment word while locked, `remote_mf_alarm` takes slot bit 5. `spare_bits[2]`, `[1]` and `[0]` take slot bits 4, 6 and 7. Both outputs read zero while not locked.
- R6: `freeze_out` goes high on `los_in`, on `slip_in` or when not locked. While it is high, no stored code changes.
- R7: While `freeze_off` is high, `freeze_out` stays low and codes update even during loss of signal.
- R8: `freeze_out` falls at the 16th slot-16 time after all fault conditions have cleared.
- R9: Frame k (1 to 15) carries channel k in slot bits 0-3 and channel k+16 in slot bits 4-7. A read strobe with `rd_ch` = c returns that channel's code on `rd_abcd` one clock later, with A in bit 3. Channels 0 and 16 read zero.
- R10: A stored code changes only when the same new value arrives in two consecutive multiframes. A single-multiframe deviation leaves the stored code unchanged.
- R11: An accepted change sets that channel's change flag. `rd_changed` returns the flag with the read data, and the read clears it.
- R12: `sig_irq` is set by any accepted change and stays high until `irq_ack`. A change that arrives together with `irq_ack` keeps it set.
- R13: After reset, `mf_lock`, `sig_irq` and `ais_ts16` are low, `freeze_out` is high and all stored codes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bit clock |
| rst | input | 1 | synchronous active-high reset |
| rx_bit | input | 1 | received serial data |
| frame_sync | input | 1 | high with bit 0 of time slot 0 |
| los_in | input | 1 | loss-of-signal condition |
| slip_in | input | 1 | receive slip pulse |
| freeze_off | input | 1 | disables automatic freeze |
| rd_en | input | 1 | host read strobe |
| rd_ch | input | 5 | channel (time slot) to read |
| irq_ack | input | 1 | clears the change interrupt |
| rd_abcd | output | 4 | ABCD code of the channel read |
| rd_changed | output | 1 | change flag of the channel read |
| mf_lock | output | 1 | multiframe alignment achieved |
| freeze_out | output | 1 | update freeze active |
| ais_ts16 | output | 1 | slot-16 AIS detected |
| remote_mf_alarm | output | 1 | remote multiframe alarm bit |
| spare_bits | output | 3 | spare bits of the alignment word |
| sig_irq | output | 1 | sticky signaling-change interrupt |

## Verification
Every slot-16 result (lock state, AIS, alarm and spare bits, freeze release and code updates) is registered one clock after the last slot-16 bit, at frame position 136. The bench therefore samples these only once a whole multiframe has been sent, well after that position. Read data and change flags appear one clock after the read strobe and are sampled on the falling edge that follows it. Freeze onset is due one clock after a fault input and is sampled inside frame 1 of the affected multiframe, and release is checked by whether the next multiframe's code is accepted.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  typedef enum logic [1:0] {MF_HUNT, MF_CONFIRM, MF_LOCK} mf_state_e;
endpackage

// File: rtl/e1cas_slot_tap.sv
module e1cas_slot_tap #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int SIG_SLOT  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_bit,
  input  logic                 frame_sync,
  output logic                 tick,
  output logic [SLOT_BITS-1:0] ts_byte
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int PW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] LAST_P = PW'(SIG_SLOT * SLOT_BITS + SLOT_BITS - 1);
  localparam logic [PW-1:0] END_P  = PW'(FRAME_BITS - 1);

  logic [PW-1:0]        pos_q, cur;
  logic [SLOT_BITS-1:0] sh_q;

  // R1: position of the bit on rx_bit this cycle
  always_comb cur = frame_sync ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= END_P;
      sh_q    <= '0;
      tick    <= 1'b0;
      ts_byte <= '0;
    end else begin
      pos_q <= (cur == END_P) ? cur : cur + 1'b1;
      sh_q  <= {sh_q[SLOT_BITS-2:0], rx_bit};
      tick  <= (cur == LAST_P);
      if (cur == LAST_P) ts_byte <= {sh_q[SLOT_BITS-2:0], rx_bit};
    end
  end

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/e1cas_mf_align.sv
module e1cas_mf_align
  import e1cas_pkg::*;
#(
  parameter int SLOT_BITS     = 8,
  parameter int MF_LEN        = 16,
  parameter int AIS_MAX_ZEROS = 3,
  localparam int FW = $clog2(MF_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [SLOT_BITS-1:0] ts_byte,
  output logic                 locked,
  output logic                 ais,
  output logic                 rem_alarm,
  output logic [2:0]           spare,
  output logic [FW-1:0]        frame_no
);
  localparam int NIB = SLOT_BITS / 2;
  localparam int ZW  = $clog2(MF_LEN * SLOT_BITS + 1);
  localparam logic [FW-1:0] LAST_F = FW'(MF_LEN - 1);

  mf_state_e     state_q;
  logic [FW-1:0] fnum_q, nf;
  logic          err_q, fa_ok;
  logic [ZW-1:0] zacc_q, zb, ztot;

  always_comb begin
    nf       = (fnum_q == LAST_F) ? '0 : fnum_q + 1'b1;
    fa_ok    = (ts_byte[SLOT_BITS-1 -: NIB] == '0);
    zb       = ZW'(SLOT_BITS - $countones(ts_byte));
    ztot     = zacc_q + zb;
    frame_no = nf;
    locked   = (state_q == MF_LOCK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= MF_HUNT;
      fnum_q    <= '0;
      err_q     <= 1'b0;
      zacc_q    <= '0;
      ais       <= 1'b0;
      rem_alarm <= 1'b0;
      spare     <= '0;
    end else if (tick) begin
      fnum_q <= nf;
      if (nf == LAST_F) begin
        zacc_q <= '0;
        ais    <= (ztot <= ZW'(AIS_MAX_ZEROS));
      end else begin
        zacc_q <= ztot;
      end
      if (state_q != MF_LOCK) begin
        rem_alarm <= 1'b0;
        spare     <= '0;
      end
      case (state_q)
        MF_HUNT: if (fa_ok) begin
          fnum_q  <= '0;
          state_q <= MF_CONFIRM;
        end
        MF_CONFIRM: if (nf == '0) begin
          state_q <= fa_ok ? MF_LOCK : MF_HUNT;
          err_q   <= 1'b0;
        end
        default: begin
          if (nf == LAST_F && ztot == ZW'(MF_LEN * SLOT_BITS)) begin
            state_q <= MF_HUNT;
          end else if (nf == '0) begin
            if (fa_ok) begin
              err_q     <= 1'b0;
              rem_alarm <= ts_byte[SLOT_BITS-6];
              spare     <= {ts_byte[SLOT_BITS-5], ts_byte[SLOT_BITS-7], ts_byte[SLOT_BITS-8]};
            end else if (err_q) begin
              state_q <= MF_HUNT;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R2
  lock_on_tick_chk: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> $past(tick));
  // R3
  unlock_on_tick_chk: assert property (@(posedge clk) disable iff (rst) $fell(locked) |-> $past(tick));
  // R4
  ais_hold_chk: assert property (@(posedge clk) disable iff (rst) !$past(tick) |-> $stable(ais));
endmodule

// File: rtl/e1cas_freeze.sv
module e1cas_freeze #(
  parameter int MF_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic los,
  input  logic slip,
  input  logic locked,
  input  logic freeze_off,
  input  logic tick,
  output logic freeze
);
  localparam int CW = $clog2(MF_LEN);
  logic [CW-1:0] cnt_q;
  logic          fault;

  always_comb fault = los | slip | ~locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze <= 1'b1;
      cnt_q  <= '0;
    end else if (freeze_off) begin
      freeze <= 1'b0;
      cnt_q  <= '0;
    end else if (fault) begin
      freeze <= 1'b1;
      cnt_q  <= '0;
    end else if (freeze && tick) begin
      if (cnt_q == CW'(MF_LEN - 1)) begin
        freeze <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  fault_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!freeze_off && (los || slip || !locked)) |=> freeze);
  // R7
  off_chk: assert property (@(posedge clk) disable iff (rst) freeze_off |=> !freeze);
  // R8
  release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze) |-> ($past(tick) || $past(freeze_off)));
endmodule

// File: rtl/e1cas_sig_bank.sv
module e1cas_sig_bank #(
  parameter int MF_LEN = 16,
  parameter int CODE_W = 4,
  localparam int FW = $clog2(MF_LEN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  locked,
  input  logic                  upd_ok,
  input  logic [FW-1:0]         frame_no,
  input  logic [2*CODE_W-1:0]   ts_byte,
  input  logic                  rd_en,
  input  logic [FW:0]           rd_ch,
  output logic [CODE_W-1:0]     rd_code,
  output logic                  rd_changed,
  output logic                  store_any
);
  logic [FW-1:0] idx;
  logic          sel_q, wr;

  always_comb begin
    idx = rd_ch[FW-1:0];
    wr  = tick && locked && (frame_no != '0);
  end

  // half 0: channels 1..15 (slot bits 0-3), half 1: channels 17..31 (bits 4-7)
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [CODE_W-1:0] store_mem [MF_LEN];
    logic [CODE_W-1:0] prev_mem  [MF_LEN];
    logic [MF_LEN-1:0] chg_q;
    logic [CODE_W-1:0] nib, rdq;
    logic              commit, chgq;

    always_comb begin
      nib    = ts_byte[(1-h)*CODE_W +: CODE_W];
      commit = wr && upd_ok && (nib == prev_mem[frame_no]) && (nib != store_mem[frame_no]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < MF_LEN; i++) begin
          store_mem[i] <= '0;
          prev_mem[i]  <= '0;
        end
        chg_q <= '0;
        rdq   <= '0;
        chgq  <= 1'b0;
      end else begin
        rdq  <= store_mem[idx];
        chgq <= chg_q[idx];
        if (wr) prev_mem[frame_no] <= nib;
        if (commit) store_mem[frame_no] <= nib;
        if (rd_en && rd_ch[FW] == 1'(h)) chg_q[idx] <= 1'b0;
        if (commit) chg_q[frame_no] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= rd_ch[FW];
  end

  always_comb begin
    rd_code    = sel_q ? g_half[1].rdq  : g_half[0].rdq;
    rd_changed = sel_q ? g_half[1].chgq : g_half[0].chgq;
    store_any  = g_half[0].commit | g_half[1].commit;
  end

  // R6
  frozen_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_ok && !rd_en && $stable(rd_ch) && $past(!upd_ok)) |=> $stable(rd_code));
endmodule

// File: rtl/e1cas_rx.sv
module e1cas_rx #(
  parameter int SLOTS         = 32,
  parameter int SLOT_BITS     = 8,
  parameter int SIG_SLOT      = 16,
  parameter int MF_LEN        = 16,
  parameter int AIS_MAX_ZEROS = 3,
  localparam int CODE_W = SLOT_BITS / 2,
  localparam int CH_W   = $clog2(MF_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              frame_sync,
  input  logic              los_in,
  input  logic              slip_in,
  input  logic              freeze_off,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              irq_ack,
  output logic [CODE_W-1:0] rd_abcd,
  output logic              rd_changed,
  output logic              mf_lock,
  output logic              freeze_out,
  output logic              ais_ts16,
  output logic              remote_mf_alarm,
  output logic [2:0]        spare_bits,
  output logic              sig_irq
);
  localparam int FW = CH_W - 1;

  logic                 tick, store_any;
  logic [SLOT_BITS-1:0] ts_byte;
  logic [FW-1:0]        frame_no;

  e1cas_slot_tap #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .SIG_SLOT(SIG_SLOT)) u_tap (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .frame_sync(frame_sync),
    .tick(tick), .ts_byte(ts_byte));

  e1cas_mf_align #(.SLOT_BITS(SLOT_BITS), .MF_LEN(MF_LEN), .AIS_MAX_ZEROS(AIS_MAX_ZEROS)) u_align (
    .clk(clk), .rst(rst), .tick(tick), .ts_byte(ts_byte),
    .locked(mf_lock), .ais(ais_ts16), .rem_alarm(remote_mf_alarm),
    .spare(spare_bits), .frame_no(frame_no));

  e1cas_freeze #(.MF_LEN(MF_LEN)) u_frz (
    .clk(clk), .rst(rst), .los(los_in), .slip(slip_in), .locked(mf_lock),
    .freeze_off(freeze_off), .tick(tick), .freeze(freeze_out));

  e1cas_sig_bank #(.MF_LEN(MF_LEN), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst(rst), .tick(tick), .locked(mf_lock), .upd_ok(!freeze_out),
    .frame_no(frame_no), .ts_byte(ts_byte), .rd_en(rd_en), .rd_ch(rd_ch),
    .rd_code(rd_abcd), .rd_changed(rd_changed), .store_any(store_any));

  // R12: sticky change interrupt, a new change beats the acknowledge
  always_ff @(posedge clk) begin
    if (rst)            sig_irq <= 1'b0;
    else if (store_any) sig_irq <= 1'b1;
    else if (irq_ack)   sig_irq <= 1'b0;
  end

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(sig_irq) |-> $past(store_any));
  // R12
  irq_ack_chk: assert property (@(posedge clk) disable iff (rst) (irq_ack && !store_any) |=> !sig_irq);
  // R6
  no_frozen_irq_chk: assert property (@(posedge clk) disable iff (rst) $rose(sig_irq) |-> $past(!freeze_out));
endmodule

// File: tb/e1cas_rx_test.sv
module e1cas_rx_test;
  logic       clk = 1'b0, rst = 1'b1;
  logic       rx_bit = 1'b1, frame_sync = 1'b0, los_in = 1'b0, slip_in = 1'b0;
  logic       freeze_off = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
  logic [4:0] rd_ch = '0;
  logic [3:0] rd_abcd;
  logic       rd_changed, mf_lock, freeze_out, ais_ts16, remote_mf_alarm, sig_irq;
  logic [2:0] spare_bits;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0, inj_slip = 0, mid_frz = 0;
  logic [3:0] cur [32];
  logic [3:0] exp_st [32];

  e1cas_rx uut (.*);

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R1: frame bit 0 with frame_sync, slot 16 at bits 128..135, slot bit 0 first
  task automatic send_frame(input logic [7:0] ts16, input bit sample);
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      frame_sync = (b == 0);
      slip_in    = (b == 0) && inj_slip;
      rx_bit     = (b >= 128 && b < 136) ? ts16[7 - (b - 128)] : 1'b1;
      if (sample && b == 8) mid_frz = freeze_out;
    end
    inj_slip = 0;
  endtask

  task automatic send_mf(input bit fa_good, input bit y, input logic [2:0] x);
    send_frame({fa_good ? 4'h0 : 4'hF, x[2], y, x[1], x[0]}, 1'b0);
    for (int k = 1; k < 16; k++) send_frame({cur[k], cur[k+16]}, k == 1);
  endtask

  task automatic send_raw_mf(input logic [7:0] v, input logic [7:0] f5);
    for (int k = 0; k < 16; k++) send_frame((k == 5) ? f5 : v, 1'b0);
  endtask

  task automatic rd(input int ch, output logic [3:0] code, output logic chg);
    @(negedge clk); rd_ch = 5'(ch); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; code = rd_abcd; chg = rd_changed;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [3:0] c; logic g;
    repeat (3) @(negedge clk);
    check("R13 mf_lock", mf_lock, 0);
    check("R13 freeze_out", freeze_out, 1);
    check("R13 sig_irq", sig_irq, 0);
    check("R13 ais_ts16", ais_ts16, 0);
    rd(1, c, g);
    check("R13 code ch1", c, 0);
  endtask

  task automatic t_lock();
    logic [3:0] c; logic g;
    send_mf(1, 0, 0);
    check("R2 no lock after one word", mf_lock, 0);
    send_mf(1, 0, 0);
    check("R2 lock after two words", mf_lock, 1);
    check("R8 freeze held after lock", freeze_out, 1);
    rd(2, c, g);
    check("R6 no update while frozen", c, 0);
    send_mf(1, 0, 0);
    check("R8 freeze released", freeze_out, 0);
    check("R12 irq on first codes", sig_irq, 1);
    for (int ch = 0; ch < 32; ch++) begin
      rd(ch, c, g);
      check($sformatf("R9 R1 code ch%0d", ch), c, exp_st[ch]);
      check($sformatf("R11 flag ch%0d", ch), g, (ch % 16) != 0);
    end
    rd(2, c, g);
    check("R11 flag cleared by read", g, 0);
  endtask

  task automatic t_irq();
    ack();
    check("R12 irq cleared by ack", sig_irq, 0);
    send_mf(1, 0, 0);
    check("R12 no irq when codes unchanged", sig_irq, 0);
  endtask

  task automatic t_lastlook();
    logic [3:0] c; logic g;
    cur[5] = 4'hC;
    send_mf(1, 0, 0);
    cur[5] = exp_st[5];
    send_mf(1, 0, 0);
    rd(5, c, g);
    check("R10 single deviation ignored", c, exp_st[5]);
    check("R12 no irq on deviation", sig_irq, 0);
    cur[20] = 4'h6;
    send_mf(1, 0, 0);
    rd(20, c, g);
    check("R10 first new value not stored", c, exp_st[20]);
    send_mf(1, 0, 0);
    exp_st[20] = 4'h6;
    rd(20, c, g);
    check("R10 second new value stored", c, 6);
    check("R11 flag set on change", g, 1);
    check("R12 irq on change", sig_irq, 1);
    ack();
  endtask

  task automatic t_alarm();
    send_mf(1, 1, 3'b101);
    check("R5 remote alarm", remote_mf_alarm, 1);
    check("R5 spare bits", spare_bits, 5);
    send_mf(1, 0, 3'b010);
    check("R5 remote alarm clear", remote_mf_alarm, 0);
    check("R5 spare bits 010", spare_bits, 2);
  endtask

  task automatic t_slip();
    logic [3:0] c; logic g;
    cur[3] = 4'h9;
    send_mf(1, 0, 0);
    inj_slip = 1;
    send_mf(1, 0, 0);
    check("R6 freeze after slip", mid_frz, 1);
    rd(3, c, g);
    check("R6 slip blocks update", c, exp_st[3]);
    send_mf(1, 0, 0);
    check("R8 freeze gone one multiframe later", mid_frz, 0);
    exp_st[3] = 4'h9;
    rd(3, c, g);
    check("R8 update after release", c, 9);
    ack();
  endtask

  task automatic t_los();
    logic [3:0] c; logic g;
    freeze_off = 1; los_in = 1;
    cur[7] = 4'h2;
    send_mf(1, 0, 0);
    send_mf(1, 0, 0);
    exp_st[7] = 4'h2;
    check("R7 no freeze when disabled", freeze_out, 0);
    rd(7, c, g);
    check("R7 update during LOS", c, 2);
    freeze_off = 0;
    repeat (2) @(negedge clk);
    check("R6 LOS freezes", freeze_out, 1);
    cur[7] = 4'hA;
    send_mf(1, 0, 0);
    send_mf(1, 0, 0);
    rd(7, c, g);
    check("R6 LOS blocks update", c, 2);
    los_in = 0;
    send_mf(1, 0, 0);
    check("R8 release after LOS clears", freeze_out, 0);
    send_mf(1, 0, 0);
    exp_st[7] = 4'hA;
    rd(7, c, g);
    check("R6 update after LOS", c, 10);
    ack();
  endtask

  task automatic t_loss();
    send_mf(0, 0, 0);
    check("R3 one bad word tolerated", mf_lock, 1);
    send_mf(0, 0, 0);
    check("R3 two bad words lose lock", mf_lock, 0);
    check("R6 freeze on unlock", freeze_out, 1);
    check("R5 alarm zero when unlocked", remote_mf_alarm, 0);
  endtask

  task automatic t_ais();
    send_raw_mf(8'hFF, 8'hFF);
    check("R4 AIS all ones", ais_ts16, 1);
    send_raw_mf(8'hFF, 8'hF1);
    check("R4 AIS three zeros", ais_ts16, 1);
    send_raw_mf(8'hFF, 8'hF0);
    check("R4 no AIS four zeros", ais_ts16, 0);
    send_raw_mf(8'hFF, 8'hFF);
    check("R4 AIS again", ais_ts16, 1);
  endtask

  task automatic t_zero();
    send_mf(1, 0, 0);
    send_mf(1, 0, 0);
    check("R2 relock", mf_lock, 1);
    check("R4 AIS cleared", ais_ts16, 0);
    send_raw_mf(8'h00, 8'h00);
    check("R3 all-zero multiframe loses lock", mf_lock, 0);
  endtask

  initial begin
    for (int ch = 0; ch < 32; ch++) begin
      cur[ch]    = 4'(((ch * 5) % 15) + 1);
      exp_st[ch] = (ch % 16 == 0) ? 4'h0 : cur[ch];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_irq();
    t_lastlook();
    t_alarm();
    t_slip();
    t_los();
    t_loss();
    t_ais();
    t_zero();
    done = 1;
    finish_run();
  end
endmodule